// File: doc/BRIEF.md
# Instruction-Set State Tracker and Fetch Aligner

This block keeps the one-bit instruction-set state of a processor front end. The processor either runs 32-bit, word-aligned wide instructions or 16-bit, halfword-aligned compact instructions. A branch-exchange request switches the state according to bit 0 of its target operand. An exception entry always forces the wide state. It records the state that was active, and a later exception return restores that state.

Each cycle the block also takes the 32-bit little-endian word fetched for the current program counter and produces the instruction to decode. In the wide state this is the whole word. In the compact state it is the halfword picked by program-counter bit 1, zero-extended to 32 bits. On a branch-exchange or an exception entry it loads a redirect program counter. On an exception entry it also captures the interrupted program counter as the link value. All outputs are registered and appear one clock after the request.

Top module: `isa_state_align`

## Requirements
- R1: A branch-exchange request whose target has bit 0 = 1 sets the state flag to compact (1) one cycle later. This also holds when an exception return arrives in the same cycle.
- R2: A branch-exchange request whose target has bit 0 = 0 sets the state flag to wide (0) one cycle later.
- R3: An exception entry produces four results one cycle later. The state flag is forced to wide. The link output holds the program counter presented with the request. The next PC is the vector with bits 1:0 cleared. The redirect flag is high. Exception entry wins over a branch-exchange or an exception return in the same cycle.
- R4: An exception return sets the state flag, one cycle later, to the value it had just before the most recent exception entry. With no entry since reset, it returns to wide.
- R5: In the compact state, the instruction output one cycle later depends on program-counter bit 1. With bit 1 = 0 it is fetch bits 15:0. With bit 1 = 1 it is fetch bits 31:16. Bits 31:16 of the output are zero. Memory is little endian: byte address n mod 4 sits in bits 8n+7:8n.
- R6: In the wide state, the instruction output one cycle later is the full fetched word.
- R7: On a branch-exchange, the next PC is the target with bit 0 cleared. When the new state is wide, bit 1 is also cleared. The redirect flag is high for that one cycle.
- R8: An exception return on its own changes only the state flag. The next PC and the link output hold, and the redirect flag stays low.
- R9: A synchronous active-high reset gives the following outputs: state wide, saved state cleared, next PC = RESET_VECTOR, link = 0, instruction = 0, redirect low.
- R10: In a cycle with no request, the redirect flag is low one cycle later and the next PC, link and state flag hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bx_valid | input | 1 | Branch-exchange request |
| bx_target | input | AW | Branch-exchange operand; bit 0 selects the new state |
| exc_valid | input | 1 | Exception entry request |
| exc_vector | input | AW | Exception vector address |
| eret_valid | input | 1 | Exception return request |
| pc_in | input | AW | Current program counter |
| fetch_word | input | DW | Word fetched at the current program counter |
| compact_o | output | 1 | State flag: 1 = compact 16-bit, 0 = wide 32-bit |
| next_pc_o | output | AW | Redirect program counter |
| redirect_o | output | 1 | Next PC was loaded in the previous cycle |
| link_o | output | AW | Program counter captured on exception entry |
| instr_o | output | DW | Aligned instruction |

## Verification
Every result of this block is due exactly one clock edge after its request. This covers the state flag, next PC, redirect flag, link value and aligned instruction. The instruction is aligned with the state flag that was visible while the fetch word was presented. The bench drives each request just after a falling edge and lets one rising edge pass. It samples at the following falling edge, then clears the request before the next rising edge, so each check sees the effect of exactly one stimulus. The checks for held values look one cycle after an idle or return-only stimulus. At that point any unwanted update would already be visible.

// File: rtl/isa_align_pkg.sv
package isa_align_pkg;

  typedef enum logic {
    ST_WIDE    = 1'b0,
    ST_COMPACT = 1'b1
  } isa_state_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_EXC  = 2'd1,
    EV_BX   = 2'd2,
    EV_ERET = 2'd3
  } isa_event_e;

  function automatic isa_event_e pick_event(input logic exc, input logic bx,
                                            input logic eret);
    if (exc)       return EV_EXC;
    else if (bx)   return EV_BX;
    else if (eret) return EV_ERET;
    else           return EV_NONE;
  endfunction

endpackage

// File: rtl/isa_event_arb.sv
module isa_event_arb
  import isa_align_pkg::*;
(
  input  logic       exc_valid,
  input  logic       bx_valid,
  input  logic       eret_valid,
  output isa_event_e ev
);

  always_comb begin
    ev = pick_event(exc_valid, bx_valid, eret_valid);
  end

endmodule

// File: rtl/isa_state_ctl.sv
module isa_state_ctl
  import isa_align_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  isa_event_e ev,
  input  logic       bx_sel,
  output logic       compact,
  output logic       saved
);

  isa_state_e state_q;
  logic       saved_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WIDE;
      saved_q <= 1'b0;
    end else begin
      unique case (ev)
        EV_EXC: begin
          saved_q <= state_q;
          state_q <= ST_WIDE;
        end
        EV_BX:   state_q <= bx_sel ? ST_COMPACT : ST_WIDE;
        EV_ERET: state_q <= saved_q ? ST_COMPACT : ST_WIDE;
        default: state_q <= state_q;
      endcase
    end
  end

  assign compact = (state_q == ST_COMPACT);
  assign saved   = saved_q;

endmodule

// File: rtl/isa_pc_redirect.sv
module isa_pc_redirect
  import isa_align_pkg::*;
#(
  parameter int unsigned     AW           = 32,
  parameter logic [AW-1:0]   RESET_VECTOR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  isa_event_e    ev,
  input  logic [AW-1:0] bx_target,
  input  logic [AW-1:0] exc_vector,
  input  logic [AW-1:0] pc_in,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] link,
  output logic          redirect
);

  logic [AW-1:0] bx_pc;
  logic [AW-1:0] vec_pc;

  always_comb begin
    bx_pc     = bx_target;
    bx_pc[0]  = 1'b0;
    if (!bx_target[0]) bx_pc[1] = 1'b0;
    vec_pc    = exc_vector;
    vec_pc[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc  <= RESET_VECTOR;
      link     <= '0;
      redirect <= 1'b0;
    end else begin
      redirect <= 1'b0;
      unique case (ev)
        EV_EXC: begin
          next_pc  <= vec_pc;
          link     <= pc_in;
          redirect <= 1'b1;
        end
        EV_BX: begin
          next_pc  <= bx_pc;
          redirect <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/isa_fetch_align.sv
module isa_fetch_align #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          compact,
  input  logic          half_sel,
  input  logic [DW-1:0] fetch_word,
  output logic [DW-1:0] instr
);

  localparam int unsigned HW = DW / 2;

  logic [HW-1:0] half;
  logic [DW-1:0] aligned;

  always_comb begin
    half    = half_sel ? fetch_word[DW-1:HW] : fetch_word[HW-1:0];
    aligned = compact ? {{HW{1'b0}}, half} : fetch_word;
  end

  always_ff @(posedge clk) begin
    if (rst) instr <= '0;
    else     instr <= aligned;
  end

endmodule

// File: rtl/isa_state_align.sv
module isa_state_align
  import isa_align_pkg::*;
#(
  parameter int unsigned   AW           = 32,
  parameter int unsigned   DW           = 32,
  parameter logic [AW-1:0] RESET_VECTOR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bx_valid,
  input  logic [AW-1:0] bx_target,
  input  logic          exc_valid,
  input  logic [AW-1:0] exc_vector,
  input  logic          eret_valid,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] fetch_word,
  output logic          compact_o,
  output logic [AW-1:0] next_pc_o,
  output logic          redirect_o,
  output logic [AW-1:0] link_o,
  output logic [DW-1:0] instr_o
);

  isa_event_e ev;
  logic       compact_w;
  logic       saved_w;

  isa_event_arb i_arb (
    .exc_valid (exc_valid),
    .bx_valid  (bx_valid),
    .eret_valid(eret_valid),
    .ev        (ev)
  );

  isa_state_ctl i_state (
    .clk    (clk),
    .rst    (rst),
    .ev     (ev),
    .bx_sel (bx_target[0]),
    .compact(compact_w),
    .saved  (saved_w)
  );

  isa_pc_redirect #(.AW(AW), .RESET_VECTOR(RESET_VECTOR)) i_pc (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .bx_target (bx_target),
    .exc_vector(exc_vector),
    .pc_in     (pc_in),
    .next_pc   (next_pc_o),
    .link      (link_o),
    .redirect  (redirect_o)
  );

  isa_fetch_align #(.DW(DW)) i_align (
    .clk       (clk),
    .rst       (rst),
    .compact   (compact_w),
    .half_sel  (pc_in[1]),
    .fetch_word(fetch_word),
    .instr     (instr_o)
  );

  assign compact_o = compact_w;

endmodule

// File: rtl/isa_state_align_chk.sv
module isa_state_align_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          bx_valid,
  input logic [AW-1:0] bx_target,
  input logic          exc_valid,
  input logic [AW-1:0] exc_vector,
  input logic          eret_valid,
  input logic [AW-1:0] pc_in,
  input logic [DW-1:0] fetch_word,
  input logic          compact_o,
  input logic [AW-1:0] next_pc_o,
  input logic          redirect_o,
  input logic [AW-1:0] link_o,
  input logic [DW-1:0] instr_o,
  input logic          saved_state
);

  localparam int unsigned HW = DW / 2;

  assert_bx_odd_R1: assert property (@(posedge clk) disable iff (rst)
    (bx_valid && !exc_valid && bx_target[0]) |=> compact_o);

  assert_bx_even_R2: assert property (@(posedge clk) disable iff (rst)
    (bx_valid && !exc_valid && !bx_target[0]) |=> !compact_o);

  assert_exc_entry_R3: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> (!compact_o && redirect_o && link_o == $past(pc_in)
                   && next_pc_o[AW-1:2] == $past(exc_vector[AW-1:2])
                   && next_pc_o[1:0] == 2'b00));

  assert_eret_restore_R4: assert property (@(posedge clk) disable iff (rst)
    (eret_valid && !bx_valid && !exc_valid) |=> compact_o == $past(saved_state));

  assert_compact_align_R5: assert property (@(posedge clk) disable iff (rst)
    compact_o |=> instr_o == {{HW{1'b0}}, ($past(pc_in[1]) ? $past(fetch_word[DW-1:HW])
                                                         : $past(fetch_word[HW-1:0]))});

  assert_wide_align_R6: assert property (@(posedge clk) disable iff (rst)
    !compact_o |=> instr_o == $past(fetch_word));

  assert_bx_pc_R7: assert property (@(posedge clk) disable iff (rst)
    (bx_valid && !exc_valid) |=> (redirect_o && !next_pc_o[0]
                                  && (compact_o || !next_pc_o[1])));

  assert_eret_only_R8: assert property (@(posedge clk) disable iff (rst)
    (eret_valid && !bx_valid && !exc_valid) |=> (!redirect_o && $stable(next_pc_o)
                                                 && $stable(link_o)));

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!eret_valid && !bx_valid && !exc_valid) |=> (!redirect_o && $stable(next_pc_o)
                                                  && $stable(link_o) && $stable(compact_o)));

endmodule

bind isa_state_align isa_state_align_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .bx_valid   (bx_valid),
  .bx_target  (bx_target),
  .exc_valid  (exc_valid),
  .exc_vector (exc_vector),
  .eret_valid (eret_valid),
  .pc_in      (pc_in),
  .fetch_word (fetch_word),
  .compact_o  (compact_o),
  .next_pc_o  (next_pc_o),
  .redirect_o (redirect_o),
  .link_o     (link_o),
  .instr_o    (instr_o),
  .saved_state(saved_w)
);

// File: tb/test_isa_state_align.sv
module test_isa_state_align;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [AW-1:0] RST_VEC = 32'h0000_0100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bx_valid = 1'b0;
  logic [AW-1:0] bx_target = '0;
  logic          exc_valid = 1'b0;
  logic [AW-1:0] exc_vector = '0;
  logic          eret_valid = 1'b0;
  logic [AW-1:0] pc_in = '0;
  logic [DW-1:0] fetch_word = '0;
  logic          compact_o;
  logic [AW-1:0] next_pc_o;
  logic          redirect_o;
  logic [AW-1:0] link_o;
  logic [DW-1:0] instr_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_state_align #(.AW(AW), .DW(DW), .RESET_VECTOR(RST_VEC)) i_isa_state_align (
    .clk(clk), .rst(rst), .bx_valid(bx_valid), .bx_target(bx_target),
    .exc_valid(exc_valid), .exc_vector(exc_vector), .eret_valid(eret_valid),
    .pc_in(pc_in), .fetch_word(fetch_word), .compact_o(compact_o),
    .next_pc_o(next_pc_o), .redirect_o(redirect_o), .link_o(link_o),
    .instr_o(instr_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    bx_valid = 1'b0; exc_valid = 1'b0; eret_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 compact", {31'b0, compact_o}, 32'h0);
    check("R9 next_pc", next_pc_o, RST_VEC);
    check("R9 link", link_o, 32'h0);
    check("R9 redirect", {31'b0, redirect_o}, 32'h0);
    check("R9 instr", instr_o, 32'h0);
  endtask

  task automatic t_eret_after_reset();
    eret_valid = 1'b1; step();
    check("R4 no entry yet, wide", {31'b0, compact_o}, 32'h0);
    check("R8 next_pc held", next_pc_o, RST_VEC);
  endtask

  task automatic t_bx_odd();
    bx_valid = 1'b1; bx_target = 32'h0000_1003; step();
    check("R1 compact", {31'b0, compact_o}, 32'h1);
    check("R7 next_pc", next_pc_o, 32'h0000_1002);
    check("R7 redirect", {31'b0, redirect_o}, 32'h1);
  endtask

  task automatic t_compact_fetch();
    fetch_word = 32'hAABB_CCDD;
    pc_in = 32'h0000_1002; step();
    check("R5 upper half", instr_o, 32'h0000_AABB);
    check("R10 redirect low", {31'b0, redirect_o}, 32'h0);
    pc_in = 32'h0000_1004; step();
    check("R5 lower half", instr_o, 32'h0000_CCDD);
    check("R10 next_pc held", next_pc_o, 32'h0000_1002);
  endtask

  task automatic t_exc_from_compact();
    exc_valid = 1'b1; exc_vector = 32'h0000_0018; pc_in = 32'h0000_1006; step();
    check("R3 wide", {31'b0, compact_o}, 32'h0);
    check("R3 link", link_o, 32'h0000_1006);
    check("R3 next_pc", next_pc_o, 32'h0000_0018);
    check("R3 redirect", {31'b0, redirect_o}, 32'h1);
  endtask

  task automatic t_wide_fetch();
    fetch_word = 32'h1234_5678; pc_in = 32'h0000_001A; step();
    check("R6 full word", instr_o, 32'h1234_5678);
  endtask

  task automatic t_eret_to_compact();
    eret_valid = 1'b1; pc_in = 32'h0000_0040; step();
    check("R4 back to compact", {31'b0, compact_o}, 32'h1);
    check("R8 next_pc held", next_pc_o, 32'h0000_0018);
    check("R8 link held", link_o, 32'h0000_1006);
    check("R8 redirect low", {31'b0, redirect_o}, 32'h0);
  endtask

  task automatic t_bx_even();
    bx_valid = 1'b1; eret_valid = 1'b1; bx_target = 32'h0000_2006; step();
    check("R2 wide", {31'b0, compact_o}, 32'h0);
    check("R7 next_pc bit1 cleared", next_pc_o, 32'h0000_2004);
  endtask

  task automatic t_exc_from_wide();
    exc_valid = 1'b1; exc_vector = 32'h0000_0008; pc_in = 32'h0000_2004; step();
    check("R3 link", link_o, 32'h0000_2004);
    eret_valid = 1'b1; step();
    check("R4 stays wide", {31'b0, compact_o}, 32'h0);
  endtask

  task automatic t_exc_priority();
    bx_valid = 1'b1; bx_target = 32'h0000_3001; step();
    check("R1 compact", {31'b0, compact_o}, 32'h1);
    exc_valid = 1'b1; exc_vector = 32'h0000_001B; pc_in = 32'h0000_3002;
    bx_valid = 1'b1; bx_target = 32'h0000_5005; step();
    check("R3 priority wide", {31'b0, compact_o}, 32'h0);
    check("R3 vector low bits cleared", next_pc_o, 32'h0000_0018);
    check("R3 link", link_o, 32'h0000_3002);
    eret_valid = 1'b1; step();
    check("R4 restored compact", {31'b0, compact_o}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_eret_after_reset();
    t_bx_odd();
    t_compact_fetch();
    t_exc_from_compact();
    t_wide_fetch();
    t_eret_to_compact();
    t_bx_even();
    t_exc_from_wide();
    t_exc_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule